// File: doc/BRIEF.md
# Strip Hit Histogrammer

This block keeps a hit count for every detector strip of one readout channel. A channel has six front-end chips with 128 strips each, so 768 strips in total. Each strip owns one 16-bit counter in a local 1024-entry memory. A hit comes in as a chip number and a strip number, qualified by a valid strip. The block turns it into a memory address and increments the counter there with a read, a modify and a write, one cycle each. A one-entry holding register keeps a hit that arrives while an update is still running. A hit that finds that register full and not being emptied is lost, and a sticky flag records the loss. A full system places one copy of this block behind each channel's deserializer.

A measurement starts with a clear request. The controller then writes zero to every address, one address per cycle, and holds `busy` high while it does so. When the last address is written it pulses `clear_done` for one cycle. Hits are then accumulated while triggers run. Afterwards the host reads the counters back one address at a time through a simple read port that returns data one cycle later.

The controller is a five-state machine:
- IDLE waits for work. From IDLE, a clear request goes to CLEAR. Otherwise a host read is served and the machine stays in IDLE. Otherwise a held hit is taken and the machine goes to READ.
- CLEAR writes zero at the clear pointer each cycle. After the last address it returns to IDLE.
- READ fetches the counter and always moves on to MODIFY.
- MODIFY forms the incremented value and always moves on to WRITE.
- WRITE stores the new value. It goes to READ if another hit is held, and to IDLE otherwise.

Top module: `strip_hit_histogram`

## Requirements
- R1: A valid hit with chip c (0 to 5) and strip s (0 to 127) increments the counter at address c*128+s, that is {chip, strip}. The counter of no other address changes.
- R2: Each counted hit is processed in three cycles (READ, MODIFY, WRITE). For one isolated hit, `idle` is high in the cycle after the hit is sampled, then low for exactly three cycles, then high again.
- R3: A hit whose chip number is 6 or 7 (addresses 768 to 1023) is discarded. No counter changes and `idle` stays high.
- R4: A counter saturates at all ones (16'hFFFF at the default width). Further hits leave it at all ones and never wrap it to zero.
- R5: A hit that arrives in the cycle right after another hit is held and counted. Two back-to-back hits both count and do not set `drop_flag`.
- R6: If a hit arrives while the holding register is full and is not being emptied in that cycle, that hit is discarded and `drop_flag` is set. Three hits in three consecutive cycles count the first two, discard the third, and set the flag. The flag stays set until the next accepted clear.
- R7: A clear request accepted in IDLE holds `busy` high for exactly 1024 cycles and writes zero to every address. It empties the holding register and resets `drop_flag`. `clear_done` is high for exactly one cycle, the first cycle after `busy` falls.
- R8: Hits that arrive while `busy` is high are ignored. They change no counter and do not set `drop_flag`.
- R9: A host read with `rd_en` high while the block is in IDLE, and with no clear request in the same cycle, returns the counter at `rd_addr` on `rd_data`, with `rd_valid` high, in the following cycle. A read request made when the block is not in IDLE is ignored and `rd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Hit strobe, one hit per cycle |
| hit_chip | input | 3 | Chip number of the hit |
| hit_strip | input | 7 | Strip number within the chip |
| clear_req | input | 1 | Start a clear (accepted in IDLE only) |
| busy | output | 1 | High while the clear is running |
| clear_done | output | 1 | One-cycle pulse when the clear finishes |
| idle | output | 1 | Controller is in IDLE |
| drop_flag | output | 1 | Sticky: a hit was lost because the holding register was full |
| rd_en | input | 1 | Host read request |
| rd_addr | input | 10 | Host read address |
| rd_valid | output | 1 | `rd_data` holds the requested counter |
| rd_data | output | 16 | Counter value that was read |

## Verification
The increment path is tested with hit patterns of increasing density:
- Isolated hits spaced a few cycles apart check the address mapping and the three-cycle update length.
- Pairs of back-to-back hits show that the holding register catches a hit that arrives during an update.
- Triples in consecutive cycles are the shortest pattern that overflows the holding register, so they separate a correct drop path from one that silently overwrites the held hit or counts every hit.
- Hits to chips 6 and 7 check that addresses beyond the 768 strips are rejected.

A long run of hits to the last valid strip, built with a narrower counter, reaches saturation. Hits and reads issued during a clear check that nothing leaks into the freshly zeroed memory.

// File: rtl/hist_pkg.sv
package hist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_READ,
        ST_MODIFY,
        ST_WRITE
    } hist_state_e;

endpackage

// File: rtl/hist_ram.sv
module hist_ram #(
    parameter int DEPTH = 1024,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/hit_skid.sv
module hit_skid #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic          pop,
    input  logic          flush,
    output logic          full,
    output logic [AW-1:0] addr,
    output logic          drop
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            addr <= '0;
            drop <= 1'b0;
        end else if (flush) begin
            full <= 1'b0;
            drop <= 1'b0;
        end else if (in_valid) begin
            if (full && !pop) begin
                // Slot occupied and not draining: keep the held hit, lose the new one.
                drop <= 1'b1;
            end else begin
                full <= 1'b1;
                addr <= in_addr;
            end
        end else if (pop) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl
    import hist_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_req,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic             skid_full,
    input  logic [AW-1:0]    skid_addr,
    output logic             skid_pop,
    output logic             skid_flush,
    output logic             ram_re,
    output logic [AW-1:0]    ram_raddr,
    input  logic [CNT_W-1:0] ram_rdata,
    output logic             ram_we,
    output logic [AW-1:0]    ram_waddr,
    output logic [CNT_W-1:0] ram_wdata,
    output logic             busy,
    output logic             idle,
    output logic             clear_done,
    output logic             rd_valid
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    hist_state_e state, next_state;
    logic [AW-1:0]    cur_addr;
    logic [AW-1:0]    clr_addr;
    logic [CNT_W-1:0] sum;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    // Next state and outputs
    always_comb begin
        next_state = state;
        skid_pop   = 1'b0;
        skid_flush = 1'b0;
        ram_re     = 1'b0;
        ram_raddr  = cur_addr;
        ram_we     = 1'b0;
        ram_waddr  = cur_addr;
        ram_wdata  = sum;
        unique case (state)
            ST_IDLE: begin
                if (clear_req) begin
                    skid_flush = 1'b1;
                    next_state = ST_CLEAR;
                end else if (rd_en) begin
                    ram_re    = 1'b1;
                    ram_raddr = rd_addr;
                end else if (skid_full) begin
                    skid_pop   = 1'b1;
                    next_state = ST_READ;
                end
            end
            ST_CLEAR: begin
                ram_we    = 1'b1;
                ram_waddr = clr_addr;
                ram_wdata = '0;
                if (clr_addr == LAST_ADDR) begin
                    next_state = ST_IDLE;
                end
            end
            ST_READ: begin
                ram_re     = 1'b1;
                next_state = ST_MODIFY;
            end
            ST_MODIFY: begin
                next_state = ST_WRITE;
            end
            ST_WRITE: begin
                ram_we = 1'b1;
                if (skid_full) begin
                    skid_pop   = 1'b1;
                    next_state = ST_READ;
                end else begin
                    next_state = ST_IDLE;
                end
            end
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            clr_addr   <= '0;
            sum        <= '0;
            clear_done <= 1'b0;
            rd_valid   <= 1'b0;
        end else begin
            if (skid_pop) begin
                cur_addr <= skid_addr;
            end
            if (state == ST_IDLE && clear_req) begin
                clr_addr <= '0;
            end else if (state == ST_CLEAR) begin
                clr_addr <= clr_addr + 1'b1;
            end
            if (state == ST_MODIFY) begin
                sum <= (&ram_rdata) ? ram_rdata : ram_rdata + 1'b1;
            end
            clear_done <= (state == ST_CLEAR) && (next_state == ST_IDLE);
            rd_valid   <= (state == ST_IDLE) && !clear_req && rd_en;
        end
    end

    assign busy = (state == ST_CLEAR);
    assign idle = (state == ST_IDLE);

endmodule

// File: rtl/strip_hit_histogram.sv
module strip_hit_histogram #(
    parameter int N_CHIPS     = 6,
    parameter int CHIP_STRIPS = 128,
    parameter int DEPTH       = 1024,
    parameter int CNT_W       = 16,
    localparam int ADDR_W     = $clog2(DEPTH),
    localparam int STRIP_W    = $clog2(CHIP_STRIPS),
    localparam int CHIP_W     = ADDR_W - STRIP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_valid,
    input  logic [CHIP_W-1:0]  hit_chip,
    input  logic [STRIP_W-1:0] hit_strip,
    input  logic               clear_req,
    output logic               busy,
    output logic               clear_done,
    output logic               idle,
    output logic               drop_flag,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_valid,
    output logic [CNT_W-1:0]   rd_data
);

    logic              hit_ok;
    logic              skid_full, skid_pop, skid_flush;
    logic [ADDR_W-1:0] skid_addr;
    logic              ram_re, ram_we;
    logic [ADDR_W-1:0] ram_raddr, ram_waddr;
    logic [CNT_W-1:0]  ram_rdata, ram_wdata;

    assign hit_ok = hit_valid && !busy &&
                    ({1'b0, hit_chip} < (CHIP_W + 1)'(N_CHIPS));

    hit_skid #(.AW(ADDR_W)) u_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (hit_ok),
        .in_addr  ({hit_chip, hit_strip}),
        .pop      (skid_pop),
        .flush    (skid_flush),
        .full     (skid_full),
        .addr     (skid_addr),
        .drop     (drop_flag)
    );

    hist_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_req  (clear_req),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .skid_full  (skid_full),
        .skid_addr  (skid_addr),
        .skid_pop   (skid_pop),
        .skid_flush (skid_flush),
        .ram_re     (ram_re),
        .ram_raddr  (ram_raddr),
        .ram_rdata  (ram_rdata),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .ram_wdata  (ram_wdata),
        .busy       (busy),
        .idle       (idle),
        .clear_done (clear_done),
        .rd_valid   (rd_valid)
    );

    hist_ram #(.DEPTH(DEPTH), .W(CNT_W)) u_ram (
        .clk   (clk),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata)
    );

    assign rd_data = ram_rdata;

endmodule

// File: rtl/strip_hist_checks.sv
module strip_hist_checks #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16,
    parameter int USED   = 768
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              idle,
    input logic              clear_req,
    input logic              clear_done,
    input logic              drop_flag,
    input logic              rd_en,
    input logic              rd_valid,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_waddr,
    input logic [CNT_W-1:0]  ram_wdata
);

    // R3: increments only land on the used strip range
    a_r3_used_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !busy) |-> ({1'b0, ram_waddr} < (ADDR_W + 1)'(USED)));

    // R4: an increment never wraps a counter to zero
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !busy) |-> (ram_wdata != '0));

    // R6: the drop flag holds until a clear is accepted
    a_r6_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_flag && !(idle && clear_req)) |=> drop_flag);

    // R7: writes during a clear store zero
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && busy) |-> (ram_wdata == '0));

    // R7: done follows the end of a clear and lasts one cycle
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        clear_done |-> ($past(busy) && !busy));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clear_done |=> !clear_done);

    // R9: read data only answers a request made in IDLE
    a_r9_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(idle && rd_en && !clear_req));

endmodule

bind strip_hit_histogram strip_hist_checks #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .USED   (N_CHIPS * CHIP_STRIPS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .idle       (idle),
    .clear_req  (clear_req),
    .clear_done (clear_done),
    .drop_flag  (drop_flag),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .ram_wdata  (ram_wdata)
);

// File: tb/sim_strip_hit_histogram.sv
module sim_strip_hit_histogram;

    localparam int BW = 8;   // narrow counters so saturation is reachable

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hit_valid = 1'b0;
    logic [2:0]    hit_chip = '0;
    logic [6:0]    hit_strip = '0;
    logic          clear_req = 1'b0;
    logic          busy, clear_done, idle, drop_flag;
    logic          rd_en = 1'b0;
    logic [9:0]    rd_addr = '0;
    logic          rd_valid;
    logic [BW-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    strip_hit_histogram #(.CNT_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_chip(hit_chip),
        .hit_strip(hit_strip), .clear_req(clear_req), .busy(busy),
        .clear_done(clear_done), .idle(idle), .drop_flag(drop_flag),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic hit(input int c, input int s, input int gap);
        hit_valid = 1'b1; hit_chip = 3'(c); hit_strip = 7'(s);
        step(1);
        hit_valid = 1'b0;
        step(gap);
    endtask

    task automatic read_expect(input string req, input int a, input int exp);
        rd_en = 1'b1; rd_addr = 10'(a);
        step(1);
        rd_en = 1'b0;
        chk({req, " rd_valid"}, int'(rd_valid), 1);
        chk({req, " rd_data"}, int'(rd_data), exp);
    endtask

    task automatic run_clear(input bit traffic);
        int n;
        clear_req = 1'b1;
        step(1);
        clear_req = 1'b0;
        n = 0;
        while (busy && n < 5000) begin
            n++;
            hit_valid = traffic && (n >= 5) && (n < 9);
            hit_chip  = 3'd0;
            hit_strip = 7'(100 + n);
            rd_en     = traffic && (n >= 20) && (n < 22);
            rd_addr   = 10'd401;
            step(1);
            if (traffic) chk("R9 no read while busy", int'(rd_valid), 0);
        end
        hit_valid = 1'b0; rd_en = 1'b0;
        chk("R7 busy length", n, 1024);
        chk("R7 done pulse", int'(clear_done), 1);
        step(1);
        chk("R7 done one cycle", int'(clear_done), 0);
        chk("R7 drop reset", int'(drop_flag), 0);
    endtask

    task automatic t_reset;
        chk("R7 reset busy", int'(busy), 0);
        chk("R9 reset rd_valid", int'(rd_valid), 0);
        chk("R6 reset drop", int'(drop_flag), 0);
        chk("R2 reset idle", int'(idle), 1);
    endtask

    task automatic t_clear_plain;
        run_clear(1'b0);
        read_expect("R7 zero 0", 0, 0);
        read_expect("R7 zero 767", 767, 0);
        read_expect("R7 zero 1023", 1023, 0);
    endtask

    task automatic t_update_timing;
        int lows;
        hit_valid = 1'b1; hit_chip = 3'd0; hit_strip = 7'd5;
        step(1);
        hit_valid = 1'b0;
        chk("R2 idle after hit sampled", int'(idle), 1);
        lows = 0;
        for (int i = 0; i < 3; i++) begin
            step(1);
            if (!idle) lows++;
        end
        chk("R2 three busy cycles", lows, 3);
        step(1);
        chk("R2 idle again", int'(idle), 1);
        read_expect("R2 count one", 5, 1);
        read_expect("R1 neighbour untouched", 4, 0);
    endtask

    task automatic t_mapping;
        hit(3, 17, 6);
        hit(3, 17, 6);
        hit(1, 0, 6);
        read_expect("R1 chip3 strip17", 3 * 128 + 17, 2);
        read_expect("R1 chip1 strip0", 128, 1);
        read_expect("R1 chip0 strip17", 17, 0);
    endtask

    task automatic t_out_of_range;
        int stay;
        hit_valid = 1'b1; hit_chip = 3'd6; hit_strip = 7'd0;
        step(1);
        hit_chip = 3'd7; hit_strip = 7'd127;
        step(1);
        hit_valid = 1'b0;
        stay = 0;
        for (int i = 0; i < 5; i++) begin
            if (idle) stay++;
            step(1);
        end
        chk("R3 idle stays high", stay, 5);
        read_expect("R3 addr 768", 768, 0);
        read_expect("R3 addr 1023", 1023, 0);
    endtask

    task automatic t_burst_two;
        hit_valid = 1'b1; hit_chip = 3'd2; hit_strip = 7'd1;
        step(1);
        hit_strip = 7'd2;
        step(1);
        hit_valid = 1'b0;
        step(12);
        chk("R5 no drop", int'(drop_flag), 0);
        read_expect("R5 first", 2 * 128 + 1, 1);
        read_expect("R5 second", 2 * 128 + 2, 1);
    endtask

    task automatic t_burst_three;
        hit_valid = 1'b1; hit_chip = 3'd4; hit_strip = 7'd10;
        step(1);
        hit_strip = 7'd11;
        step(1);
        hit_strip = 7'd12;
        step(1);
        hit_valid = 1'b0;
        step(20);
        chk("R6 drop set", int'(drop_flag), 1);
        read_expect("R6 first", 4 * 128 + 10, 1);
        read_expect("R6 second", 4 * 128 + 11, 1);
        read_expect("R6 third dropped", 4 * 128 + 12, 0);
        chk("R6 drop sticky", int'(drop_flag), 1);
    endtask

    task automatic t_clear_traffic;
        run_clear(1'b1);
        read_expect("R8 hit during clear 105", 105, 0);
        read_expect("R8 hit during clear 107", 107, 0);
        read_expect("R7 cleared 401", 401, 0);
        chk("R8 no drop", int'(drop_flag), 0);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 260; i++) hit(5, 127, 4);
        step(4);
        read_expect("R4 saturated", 767, (1 << BW) - 1);
        read_expect("R4 neighbour", 766, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_clear_plain();
        t_update_timing();
        t_mapping();
        t_out_of_range();
        t_burst_two();
        t_burst_three();
        t_clear_traffic();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule